// File: doc/BRIEF.md
# Resumable Block Hash Front End

This block sits between a register bus and an MD5/SHA-1 compression core. Software selects an algorithm and enables the engine through a control register. It then streams 32-bit message words into a data port. Each word lands in a receive FIFO. Whenever sixteen words, which make one 64-byte block, are waiting and the core is idle, the front end hands the block to the core. It hands over the current chaining state with it, then folds the core's result back in as the new chaining state.

The chaining state starts either from the algorithm's standard constants or from five software-written resume registers. This lets a hash that was suspended at a block boundary be continued. A self-clearing finish bit drains every complete block and then latches the chaining state into digest registers. The compression function, message padding and any DMA lie outside this block.

Register map, by word address: 0 control, 1 status, 2 data port, 8 to 12 resume words 0 to 4, 16 to 20 digest words 0 to 4. Control bits:

| Bit | Meaning |
|-----|---------|
| 0 | algorithm: 0 = MD5, 1 = SHA-1 |
| 1 | enable |
| 2 | resume: take the initial state from the resume registers |
| 3 | finish |

Status bits:

| Bits | Meaning |
|------|---------|
| [7:0] | free FIFO words |
| 8 | overflow |
| 9 | digest valid |

Top module: `hash_frontend`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x20 (32 free words, no overflow, no valid digest), and no start is issued.
- R2: When the enable bit (control bit 1) rises with the resume bit (control bit 2) clear, the chaining state takes the standard initial words. These are 67452301, efcdab89, 98badcfe and 10325476, plus c3d2e1f0 as a fifth word for SHA-1 only. Word 4 is zero for MD5.
- R3: When the enable bit rises with the resume bit set, the chaining state takes resume words 0 to 3 (addresses 8 to 11). For SHA-1 it also takes word 4 (address 12); for MD5, word 4 is zero.
- R4: Status bits [7:0] give the FIFO depth minus the words held. Right after enabling, this reads 32.
- R5: When at least 16 words are held and the core is idle, the block issues a one-cycle start. The oldest word goes in bits [31:0] of the block, each later word occupies the next 32 bits, and the current chaining state travels with it. Sixteen spaces are freed at that moment.
- R6: At most one block is in flight. No new start is issued until done returns, and done replaces the chaining state with the core's result.
- R7: The finish bit (control bit 3) reads 1 until no complete block is held and none is in flight, then clears by itself. The digest registers and the valid bit (status bit 9) update one cycle after that.
- R8: Digest words 0 to 3 appear at addresses 16 to 19. SHA-1 adds word 4 at address 20, which reads zero for MD5.
- R9: A data write while the FIFO is full is dropped and sets the overflow bit (status bit 8). The bit stays set until the engine is disabled.
- R10: Writing the control register with the enable bit clear empties the FIFO and clears the overflow flag, the digest and the valid bit. Data writes made while disabled are ignored.
- R11: Words that do not make up a whole block stay in the FIFO across a finish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register word address |
| reg_wdata | input | WORD_W | register write data |
| reg_rdata | output | WORD_W | register read data (combinational) |
| cmp_start | output | 1 | one-cycle start toward the compression core |
| cmp_sha1 | output | 1 | algorithm select toward the core |
| cmp_block | output | BLOCK_WORDS*WORD_W | 512-bit message block |
| cmp_state | output | 5*WORD_W | chaining state for this block |
| cmp_done | input | 1 | core result valid (one cycle) |
| cmp_result | input | 5*WORD_W | new chaining state from the core |

## Verification
Every cycle, the embedded assertions watch the following:
- the FIFO fill stays within its depth;
- starts are single pulses and never overlap a block in flight;
- the finish bit falls only when the engine is idle or being disabled;
- the overflow flag drops only on disable;
- the valid bit rises only after a capture.

Only the bench scenarios can show the rest. These cover:
- the digest values for each algorithm, with and without resumed state;
- the order of words inside a block;
- the leftover words after a finish;
- that a dropped overflow write and data written while disabled really leave the FIFO untouched.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
   localparam int CTL_ALG = 0;
   localparam int CTL_EN  = 1;
   localparam int CTL_RES = 2;
   localparam int CTL_DE  = 3;

   localparam int STS_OVF  = 8;
   localparam int STS_DVAL = 9;

   localparam int REG_CTRL = 0;
   localparam int REG_STAT = 1;
   localparam int REG_DATA = 2;
   localparam int REG_IV0  = 8;
   localparam int REG_DIG0 = 16;

   localparam int STATE_WORDS = 5;
   localparam int MD5_WORDS   = 4;

   typedef enum logic {ALG_MD5 = 1'b0, ALG_SHA1 = 1'b1} hfe_alg_e;

   function automatic logic [31:0] hfe_std_init(input int idx);
      case (idx)
         0:       return 32'h67452301;
         1:       return 32'hefcdab89;
         2:       return 32'h98badcfe;
         3:       return 32'h10325476;
         default: return 32'hc3d2e1f0;
      endcase
   endfunction
endpackage

// File: rtl/hfe_word_fifo.sv
module hfe_word_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 32,
   parameter int BLK    = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  push,
   input  logic [WORD_W-1:0]     push_word,
   input  logic                  pop_blk,
   output logic [CNT_W-1:0]      count,
   output logic                  full,
   output logic                  blk_avail,
   output logic [BLK*WORD_W-1:0] blk_words
);
   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("hfe_word_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < BLK) begin : g_bad_blk
      $error("hfe_word_fifo: DEPTH must hold at least one block");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(push);
         rd_ptr <= rd_ptr + (pop_blk ? PTR_W'(BLK) : '0);
         cnt_q  <= cnt_q + CNT_W'(push) - (pop_blk ? CNT_W'(BLK) : '0);
      end
   end

   for (genvar k = 0; k < BLK; k++) begin : g_tap
      logic [PTR_W-1:0] idx;
      assign idx = rd_ptr + PTR_W'(k);
      assign blk_words[k*WORD_W +: WORD_W] = mem[idx];
   end

   assign count     = cnt_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign blk_avail = (cnt_q >= CNT_W'(BLK));

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   assert_pop_needs_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_blk |-> blk_avail);
   assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
endmodule

// File: rtl/hfe_chain_state.sv
module hfe_chain_state
   import hfe_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int ST_W  = STATE_WORDS * WORD_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            load,
   input  logic            load_sha,
   input  logic            load_resume,
   input  logic [ST_W-1:0] iv_words,
   input  logic            upd,
   input  logic            live_sha,
   input  logic [ST_W-1:0] upd_words,
   input  logic            capture,
   input  logic            invalidate,
   output logic [ST_W-1:0] chain,
   output logic [ST_W-1:0] digest,
   output logic            dig_valid
);
   if (WORD_W != 32) begin : g_bad_width
      $error("hfe_chain_state: only 32-bit words are supported");
   end

   for (genvar i = 0; i < STATE_WORDS; i++) begin : g_word
      localparam bit ALWAYS_LIVE = (i < MD5_WORDS);
      logic [WORD_W-1:0] chain_w, dig_w;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_w <= '0;
            dig_w   <= '0;
         end else if (clear) begin
            chain_w <= '0;
            dig_w   <= '0;
         end else begin
            if (load) begin
               if (!ALWAYS_LIVE && !load_sha) chain_w <= '0;
               else if (load_resume)          chain_w <= iv_words[i*WORD_W +: WORD_W];
               else                           chain_w <= hfe_std_init(i);
            end else if (upd) begin
               chain_w <= (!ALWAYS_LIVE && !live_sha) ? '0 : upd_words[i*WORD_W +: WORD_W];
            end
            if (capture) dig_w <= chain_w;
         end
      end

      assign chain[i*WORD_W +: WORD_W]  = chain_w;
      assign digest[i*WORD_W +: WORD_W] = dig_w;
   end

   logic valid_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       valid_q <= 1'b0;
      else if (clear || invalidate)     valid_q <= 1'b0;
      else if (capture)                 valid_q <= 1'b1;
   end
   assign dig_valid = valid_q;

   assert_valid_follows_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(capture));
endmodule

// File: rtl/hfe_block_launch.sv
module hfe_block_launch #(
   parameter int BLOCK_BITS = 512
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  enable,
   input  logic                  blk_avail,
   input  logic [BLOCK_BITS-1:0] blk_words,
   input  logic                  done,
   output logic                  pop,
   output logic                  start,
   output logic                  busy,
   output logic                  upd,
   output logic [BLOCK_BITS-1:0] blk_out
);
   logic start_q, busy_q;
   logic [BLOCK_BITS-1:0] blk_q;

   assign pop = enable && blk_avail && !busy_q && !clear;
   assign upd = busy_q && done && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         start_q <= pop;
         if (clear)    busy_q <= 1'b0;
         else if (pop) busy_q <= 1'b1;
         else if (upd) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (pop) blk_q <= blk_words;
   end

   assign start   = start_q;
   assign busy    = busy_q;
   assign blk_out = blk_q;

   assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !$past(busy_q));
endmodule

// File: rtl/hash_frontend.sv
module hash_frontend
   import hfe_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int FIFO_DEPTH  = 32,
   parameter int BLOCK_WORDS = 16,
   parameter int ADDR_W      = 5,
   localparam int BLOCK_BITS = BLOCK_WORDS * WORD_W,
   localparam int ST_W       = STATE_WORDS * WORD_W,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [WORD_W-1:0]     reg_wdata,
   output logic [WORD_W-1:0]     reg_rdata,
   output logic                  cmp_start,
   output logic                  cmp_sha1,
   output logic [BLOCK_BITS-1:0] cmp_block,
   output logic [ST_W-1:0]       cmp_state,
   input  logic                  cmp_done,
   input  logic [ST_W-1:0]       cmp_result
);
   if (CNT_W > STS_OVF) begin : g_bad_cnt
      $error("hash_frontend: free-count field overlaps status flags");
   end
   if ((1 << ADDR_W) <= REG_DIG0 + STATE_WORDS - 1) begin : g_bad_addr
      $error("hash_frontend: ADDR_W too small for the register map");
   end

   hfe_alg_e alg_q;
   logic en_q, res_q, de_q, ovf_q, cap_q;
   logic [STATE_WORDS-1:0][WORD_W-1:0] iv_q;

   logic [CNT_W-1:0]      fifo_count;
   logic                  fifo_full, fifo_avail, pop, busy, upd, dig_valid;
   logic [BLOCK_BITS-1:0] fifo_words;
   logic [ST_W-1:0]       chain, digest;
   logic [STATE_WORDS-1:0][WORD_W-1:0] dig_pk;

   logic ctrl_wr, data_wr, clear, en_rise, de_done, ovf_set, invalidate;
   assign ctrl_wr    = reg_we && (reg_addr == ADDR_W'(REG_CTRL));
   assign data_wr    = reg_we && (reg_addr == ADDR_W'(REG_DATA)) && en_q;
   assign clear      = ctrl_wr && !reg_wdata[CTL_EN];
   assign en_rise    = ctrl_wr && reg_wdata[CTL_EN] && !en_q;
   assign invalidate = ctrl_wr && reg_wdata[CTL_EN] && reg_wdata[CTL_DE];
   assign ovf_set    = data_wr && fifo_full;
   assign de_done    = de_q && !ctrl_wr && !fifo_avail && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alg_q <= ALG_MD5;
         en_q  <= 1'b0;
         res_q <= 1'b0;
         de_q  <= 1'b0;
      end else if (ctrl_wr) begin
         alg_q <= hfe_alg_e'(reg_wdata[CTL_ALG]);
         en_q  <= reg_wdata[CTL_EN];
         res_q <= reg_wdata[CTL_RES];
         de_q  <= reg_wdata[CTL_EN] && (reg_wdata[CTL_DE] || de_q);
      end else if (de_done) begin
         de_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         cap_q <= 1'b0;
      end else if (clear) begin
         ovf_q <= 1'b0;
         cap_q <= 1'b0;
      end else begin
         if (ovf_set) ovf_q <= 1'b1;
         cap_q <= de_done;
      end
   end

   for (genvar i = 0; i < STATE_WORDS; i++) begin : g_iv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) iv_q[i] <= '0;
         else if (reg_we && reg_addr == ADDR_W'(REG_IV0 + i)) iv_q[i] <= reg_wdata;
      end
   end

   hfe_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .BLK(BLOCK_WORDS)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .push(data_wr && !fifo_full), .push_word(reg_wdata),
      .pop_blk(pop), .count(fifo_count), .full(fifo_full),
      .blk_avail(fifo_avail), .blk_words(fifo_words));

   hfe_block_launch #(.BLOCK_BITS(BLOCK_BITS)) u_launch (
      .clk(clk), .rst_n(rst_n), .clear(clear), .enable(en_q),
      .blk_avail(fifo_avail), .blk_words(fifo_words), .done(cmp_done),
      .pop(pop), .start(cmp_start), .busy(busy), .upd(upd), .blk_out(cmp_block));

   hfe_chain_state #(.WORD_W(WORD_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .load(en_rise), .load_sha(reg_wdata[CTL_ALG]), .load_resume(reg_wdata[CTL_RES]),
      .iv_words(iv_q), .upd(upd), .live_sha(alg_q == ALG_SHA1), .upd_words(cmp_result),
      .capture(cap_q), .invalidate(invalidate),
      .chain(chain), .digest(digest), .dig_valid(dig_valid));

   assign cmp_sha1  = (alg_q == ALG_SHA1);
   assign cmp_state = chain;
   assign dig_pk    = digest;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(REG_CTRL)) begin
         reg_rdata[CTL_ALG] = (alg_q == ALG_SHA1);
         reg_rdata[CTL_EN]  = en_q;
         reg_rdata[CTL_RES] = res_q;
         reg_rdata[CTL_DE]  = de_q;
      end else if (reg_addr == ADDR_W'(REG_STAT)) begin
         reg_rdata[CNT_W-1:0] = CNT_W'(FIFO_DEPTH) - fifo_count;
         reg_rdata[STS_OVF]   = ovf_q;
         reg_rdata[STS_DVAL]  = dig_valid;
      end
      for (int i = 0; i < STATE_WORDS; i++) begin
         if (reg_addr == ADDR_W'(REG_IV0 + i))  reg_rdata = iv_q[i];
         if (reg_addr == ADDR_W'(REG_DIG0 + i)) reg_rdata = dig_pk[i];
      end
   end

   assert_de_falls_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(de_q) |-> ($past(clear) || ($past(!busy) && $past(!fifo_avail))));
   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_q) |-> $past(clear));
   assert_empty_on_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> (fifo_count == '0));
endmodule

// File: tb/hash_frontend_tb.sv
module hash_frontend_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic cmp_start, cmp_sha1;
   logic [511:0] cmp_block;
   logic [159:0] cmp_state;
   logic cmp_done = 1'b0;
   logic [159:0] cmp_result = '0;

   int n_cmp = 0, n_mis = 0, n_starts = 0, n_overlap = 0;
   logic hold = 1'b0;

   always #5 clk = ~clk;

   hash_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_start(cmp_start),
      .cmp_sha1(cmp_sha1), .cmp_block(cmp_block), .cmp_state(cmp_state),
      .cmp_done(cmp_done), .cmp_result(cmp_result));

   function automatic logic [159:0] mix(input logic [511:0] d, input logic [159:0] s, input logic sha);
      logic [159:0] r;
      for (int i = 0; i < 5; i++) begin
         logic [31:0] w;
         w = {s[i*32 +: 29], s[i*32+29 +: 3]} ^ d[i*32 +: 32];
         w = w + d[(i+8)*32 +: 32] + 32'(i);
         if (!sha && i == 4) w = '0;
         r[i*32 +: 32] = w;
      end
      return r;
   endfunction

   function automatic logic [31:0] std_word(input int i);
      case (i)
         0: return 32'h67452301;
         1: return 32'hefcdab89;
         2: return 32'h98badcfe;
         3: return 32'h10325476;
         default: return 32'hc3d2e1f0;
      endcase
   endfunction

   function automatic logic [31:0] gen_word(input logic [31:0] seed, input int k);
      return seed ^ (32'(k) * 32'h9E3779B9) ^ 32'(k);
   endfunction

   // compression core model: fixed latency, optional hold of done
   logic pend = 1'b0;
   int lat = 0;
   logic [511:0] cap_d;
   logic [159:0] cap_s;
   logic cap_sha;
   always @(posedge clk) begin
      cmp_done <= 1'b0;
      if (cmp_start) begin
         if (pend) n_overlap <= n_overlap + 1;
         pend <= 1'b1; lat <= 3;
         cap_d <= cmp_block; cap_s <= cmp_state; cap_sha <= cmp_sha1;
         n_starts <= n_starts + 1;
      end else if (pend) begin
         if (lat <= 1) begin
            if (!hold) begin
               cmp_done <= 1'b1;
               cmp_result <= mix(cap_d, cap_s, cap_sha);
               pend <= 1'b0;
            end
         end else lat <= lat - 1;
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // finish and compare the digest against the reference chain
   task automatic finish_and_check(input logic [31:0] ctl, input logic [159:0] exp_st, input string tag);
      logic [31:0] v;
      bit cleared = 0;
      reg_wr(5'd0, ctl | 32'h8);
      for (int t = 0; t < 300; t++) begin
         reg_rd(5'd0, v);
         if (!v[3]) begin cleared = 1; break; end
         @(negedge clk);
      end
      chk({tag, " R7 finish clears"}, 32'(cleared), 32'd1);
      reg_rd(5'd1, v);
      chk({tag, " R7 valid not yet"}, 32'(v[9]), 32'd0);
      @(negedge clk);
      reg_rd(5'd1, v);
      chk({tag, " R7 valid next cycle"}, 32'(v[9]), 32'd1);
      for (int i = 0; i < 5; i++) begin
         reg_rd(5'(16 + i), v);
         chk({tag, " R8 digest word"}, v, exp_st[i*32 +: 32]);
      end
   endtask

   // {sha, resume, nwords[7:0], exp_free[7:0], seed[31:0]}
   localparam logic [49:0] VEC [6] = '{
      {1'b0, 1'b0, 8'd16, 8'd32, 32'hA1B2C3D4},
      {1'b1, 1'b0, 8'd35, 8'd29, 32'h0F1E2D3C},
      {1'b0, 1'b1, 8'd20, 8'd28, 32'h55AA0011},
      {1'b1, 1'b1, 8'd0,  8'd32, 32'h00000000},
      {1'b1, 1'b0, 8'd48, 8'd32, 32'h13579BDF},
      {1'b0, 1'b0, 8'd0,  8'd32, 32'h00000000}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_mis++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(5'd0, v); chk("R1 ctrl after reset", v, 32'h0);
      reg_rd(5'd1, v); chk("R1 status after reset", v, 32'h20);
      chk("R1 no start", 32'(cmp_start), 32'd0);

      for (int vi = 0; vi < 6; vi++) begin
         logic sha, res;
         int nw, s0;
         logic [31:0] seed, ctl, w;
         logic [159:0] ref_st;
         logic [511:0] blk;
         string tag;
         sha = VEC[vi][49]; res = VEC[vi][48]; nw = int'(VEC[vi][47:40]);
         seed = VEC[vi][31:0];
         tag = $sformatf("vec%0d", vi);
         reg_wr(5'd0, 32'h0);
         for (int i = 0; i < 5; i++) begin
            if (res) reg_wr(5'(8 + i), seed ^ (32'h11111111 * 32'(i + 1)));
         end
         for (int i = 0; i < 5; i++) begin
            ref_st[i*32 +: 32] = res ? (seed ^ (32'h11111111 * 32'(i + 1))) : std_word(i);
         end
         if (!sha) ref_st[159:128] = '0;   // R2 / R3 MD5 word 4 is zero
         s0 = n_starts;
         ctl = {29'd0, res, 1'b1, sha};
         reg_wr(5'd0, ctl);
         reg_rd(5'd1, v); chk({tag, " R4 free after enable"}, {24'd0, v[7:0]}, 32'd32);
         for (int k = 0; k < nw; k++) begin
            w = gen_word(seed, k);
            blk[(k % 16)*32 +: 32] = w;      // R5 oldest word lowest
            if (k % 16 == 15) ref_st = mix(blk, ref_st, sha);   // R6 chaining
            reg_wr(5'd2, w);
         end
         finish_and_check(ctl, ref_st, res ? {tag, " R3"} : {tag, " R2"});
         reg_rd(5'd1, v); chk({tag, " R11 leftover words kept"}, {24'd0, v[7:0]}, 32'(VEC[vi][39:32]));
         chk({tag, " R5 start count"}, 32'(n_starts - s0), 32'(nw / 16));
      end
      chk("R6 no overlapping start", 32'(n_overlap), 32'd0);

      // R9 / R6 overflow while the core holds a block
      begin
         int s0;
         reg_wr(5'd0, 32'h0);
         hold = 1'b1;
         reg_wr(5'd0, 32'h2);
         s0 = n_starts;
         for (int k = 0; k < 48; k++) reg_wr(5'd2, 32'hC0DE0000 + 32'(k));
         reg_rd(5'd1, v); chk("R9 fifo full no overflow yet", v, 32'h0);
         reg_wr(5'd2, 32'hDEADBEEF);
         reg_rd(5'd1, v); chk("R9 overflow set, write dropped", v, 32'h100);
         chk("R6 one block in flight", 32'(n_starts - s0), 32'd1);
         hold = 1'b0;
         repeat (40) @(negedge clk);
         chk("R6 queued blocks launched after done", 32'(n_starts - s0), 32'd3);
         reg_rd(5'd1, v); chk("R9 overflow sticky, fifo drained", v, 32'h120);
         reg_wr(5'd0, 32'h0);
         reg_rd(5'd1, v); chk("R10 disable clears overflow", v, 32'h20);
      end

      // R10 disable discards queued words and ignores disabled writes
      begin
         logic [159:0] md5_init;
         reg_wr(5'd0, 32'h2);
         for (int k = 0; k < 5; k++) reg_wr(5'd2, 32'h1234 + 32'(k));
         reg_rd(5'd1, v); chk("R4 free after five words", {24'd0, v[7:0]}, 32'd27);
         reg_wr(5'd0, 32'h0);
         for (int k = 0; k < 3; k++) reg_wr(5'd2, 32'h5555);
         reg_wr(5'd0, 32'h2);
         reg_rd(5'd1, v); chk("R10 fifo empty after re-enable", v, 32'h20);
         for (int i = 0; i < 4; i++) md5_init[i*32 +: 32] = std_word(i);
         md5_init[159:128] = '0;
         finish_and_check(32'h2, md5_init, "R10 restart");
         reg_wr(5'd0, 32'h0);
         reg_rd(5'd1, v); chk("R10 disable clears valid", v, 32'h20);
         reg_rd(5'd16, v); chk("R10 disable clears digest", v, 32'h0);
      end

      summary();
      $finish;
   end
endmodule